// File: doc/BRIEF.md
# Write Data Burst Reassembler

This block sits on the write path between a source that may interleave write data beats from several outstanding bursts and a sink that takes each burst's data as one unbroken run of beats. Each write address transfer carries a transaction ID and a beat count minus one. Each incoming data beat carries an ID, data, byte strobes and a last-beat marker. The block keeps a small ring of slots. It takes one slot per accepted address, in the order the addresses arrive, and uses the beat's ID to steer the beat into the oldest open slot with that ID.

A burst is replayed on the output only once all its beats are held. Bursts leave in address order, each as consecutive beats with the last-beat marker on its final beat, and the output carries no ID. Protocol violations set sticky error flags: a first beat that overtakes an older burst's first beat, a beat count too large for a slot, and a last-beat marker in the wrong place. The read channels and the write response channel do not pass through this block.

Top module: `wr_deinterleave`

## Requirements
- R1: After reset, `m_wvalid` is 0, `s_awready` is 1, `err_flags` is 0 and no slot is pending.
- R2: With DEPTH accepted addresses still pending (not yet fully replayed), `s_awready` is 0. It returns to 1 in the cycle after a slot is released.
- R3: A data beat whose ID matches no open pending burst is stalled (`s_wready` = 0), including a beat that arrives before its address. It is taken once a matching address has been accepted.
- R4: Output bursts leave in the order their addresses were accepted. Every beat carries the data and strobes received for it (strobe bit n qualifies data bits 8n+7..8n), and `m_wlast` is 1 exactly on each burst's final beat. Interleaved (A1 B1 A2 B2) and in-order (A1 A2 B1 B2) input give the same output.
- R5: Once a burst's first beat is valid on the output, `m_wvalid` stays 1 until its last beat is taken. Payload is stable while `m_wvalid` is 1 and `m_wready` is 0.
- R6: Beats that share an ID fill the oldest open burst with that ID. After its last beat, further beats with that ID go to the next burst with that ID.
- R7: A first beat that arrives while an older pending burst has received no beat sets `err_flags[0]`. The beat is still kept and replayed.
- R8: An address with beat count minus one above MAX_BEATS-1 is consumed, takes no slot and sets `err_flags[1]`. Beats with its ID then stall.
- R9: A beat whose last-beat marker disagrees with its position (marker before position AWLEN, or missing at position AWLEN) is dropped. It sets `err_flags[2]` and closes the burst with the beats already held. A burst closed with no beats produces no output.
- R10: Error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Address transfer valid |
| s_awready | output | 1 | Address transfer ready (a slot is free) |
| s_awid | input | ID_W | Transaction ID of the address |
| s_awlen | input | LEN_W | Beat count minus one |
| s_wvalid | input | 1 | Incoming data beat valid |
| s_wready | output | 1 | Incoming data beat ready |
| s_wid | input | ID_W | ID of the incoming beat |
| s_wdata | input | DATA_W | Incoming beat data |
| s_wstrb | input | DATA_W/8 | Incoming byte strobes |
| s_wlast | input | 1 | Incoming beat is the burst's last |
| m_wvalid | output | 1 | Outgoing beat valid |
| m_wready | input | 1 | Outgoing beat ready |
| m_wdata | output | DATA_W | Outgoing beat data |
| m_wstrb | output | DATA_W/8 | Outgoing byte strobes |
| m_wlast | output | 1 | Outgoing beat is the burst's last |
| err_flags | output | 3 | Sticky flags: bit0 order, bit1 length, bit2 last marker |

## Verification
`s_wready` depends combinationally on the presented ID, so the bench drives a beat, waits 1 ns and then reads the ready it will meet at the next rising edge. `s_awready` and the error flags change in the cycle after the handshake that causes them. A burst at the ring head shows its first output beat in the cycle after its final input beat is taken. All outputs are read on the falling edge. The sink decides `m_wready` on each falling edge. When it sees `m_wvalid` with its own ready high, it compares that beat at once with the head of an expected queue. That queue is filled in address order when each address is issued, so the comparison matches the handshake at the next rising edge. Error cases are followed by a full drain, and any beat that arrives with the queue empty is reported.

// File: rtl/wr_deint_pkg.sv
package wr_deint_pkg;
  localparam int ERR_W     = 3;
  localparam int ERR_ORDER = 0;
  localparam int ERR_AWLEN = 1;
  localparam int ERR_LAST  = 2;

  // What happens to an accepted incoming beat
  typedef enum logic [1:0] {
    BEAT_IDLE,
    BEAT_KEEP,
    BEAT_KEEP_CLOSE,
    BEAT_DROP_CLOSE
  } beat_act_e;
endpackage

// File: rtl/wr_deint_pick.sv
// Finds the oldest open slot whose ID matches, scanning the ring from head.
module wr_deint_pick #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4,
  parameter int PTR_W = 2
) (
  input  logic [PTR_W-1:0]            head,
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0]            slot_open,
  input  logic [DEPTH-1:0]            slot_started,
  input  logic [DEPTH-1:0][ID_W-1:0]  slot_id,
  input  logic [ID_W-1:0]             qid,
  output logic                        hit,
  output logic [PTR_W-1:0]            hit_idx,
  output logic                        older_idle
);
  logic [DEPTH-1:0][PTR_W-1:0] ord;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ord
    logic [PTR_W:0] sum;
    assign sum    = {1'b0, head} + (PTR_W+1)'(k);
    assign ord[k] = (sum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(sum - (PTR_W+1)'(DEPTH))
                                               : PTR_W'(sum);
  end

  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    older_idle = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!hit) begin
        if (slot_open[ord[k]] && (slot_id[ord[k]] == qid)) begin
          hit     = 1'b1;
          hit_idx = ord[k];
        end else if (slot_vld[ord[k]] && !slot_started[ord[k]]) begin
          older_idle = 1'b1;
        end
      end
    end
    if (!hit) older_idle = 1'b0;
  end
endmodule

// File: rtl/wr_deint_store.sv
// Beat storage: one region of MAX_BEATS words per slot, data and strobes kept together.
module wr_deint_store #(
  parameter int DEPTH     = 4,
  parameter int MAX_BEATS = 16,
  parameter int DATA_W    = 32,
  parameter int PTR_W     = 2,
  parameter int BEAT_W    = 4
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [PTR_W-1:0]      wslot,
  input  logic [BEAT_W-1:0]     wbeat,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  input  logic [PTR_W-1:0]      rslot,
  input  logic [BEAT_W-1:0]     rbeat,
  output logic [DATA_W-1:0]     rdata,
  output logic [DATA_W/8-1:0]   rstrb
);
  localparam int STRB_W  = DATA_W / 8;
  localparam int ENTRIES = DEPTH * MAX_BEATS;
  localparam int ADDR_W  = $clog2(ENTRIES);
  localparam int WORD_W  = DATA_W + STRB_W;

  logic [WORD_W-1:0] mem [ENTRIES];
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;

  assign waddr = ADDR_W'(wslot) * ADDR_W'(MAX_BEATS) + ADDR_W'(wbeat);
  assign raddr = ADDR_W'(rslot) * ADDR_W'(MAX_BEATS) + ADDR_W'(rbeat);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wstrb, wdata};
  end

  assign {rstrb, rdata} = mem[raddr];
endmodule

// File: rtl/wr_deinterleave.sv
module wr_deinterleave
  import wr_deint_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 8,
  parameter int DEPTH     = 4,
  parameter int MAX_BEATS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [ID_W-1:0]      s_awid,
  input  logic [LEN_W-1:0]     s_awlen,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  input  logic [ID_W-1:0]      s_wid,
  input  logic [DATA_W-1:0]    s_wdata,
  input  logic [DATA_W/8-1:0]  s_wstrb,
  input  logic                 s_wlast,
  output logic                 m_wvalid,
  input  logic                 m_wready,
  output logic [DATA_W-1:0]    m_wdata,
  output logic [DATA_W/8-1:0]  m_wstrb,
  output logic                 m_wlast,
  output logic [ERR_W-1:0]     err_flags
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam int CNT_W  = $clog2(MAX_BEATS + 1);

  // slot state
  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0]             done_q, done_d;
  logic [DEPTH-1:0][ID_W-1:0]   id_q, id_d;
  logic [DEPTH-1:0][BEAT_W-1:0] len_q, len_d;
  logic [DEPTH-1:0][CNT_W-1:0]  wcnt_q, wcnt_d;
  logic [PTR_W-1:0]             head_q, head_d;
  logic [PTR_W-1:0]             tail_q, tail_d;
  logic [BEAT_W-1:0]            rcnt_q, rcnt_d;
  logic [ERR_W-1:0]             err_q, err_d;

  logic [DEPTH-1:0] slot_open;
  logic [DEPTH-1:0] slot_started;
  logic             hit;
  logic [PTR_W-1:0] hit_idx;
  logic             older_idle;
  logic             aw_fire;
  logic             w_fire;
  logic             r_fire;
  logic             len_bad;
  logic             at_end;
  logic             head_ready;
  logic             head_empty;
  beat_act_e        act;
  logic             mem_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_flags
    assign slot_open[i]    = vld_q[i] & ~done_q[i];
    assign slot_started[i] = done_q[i] | (wcnt_q[i] != '0);
  end

  wr_deint_pick #(
    .DEPTH (DEPTH),
    .ID_W  (ID_W),
    .PTR_W (PTR_W)
  ) u_pick (
    .head         (head_q),
    .slot_vld     (vld_q),
    .slot_open    (slot_open),
    .slot_started (slot_started),
    .slot_id      (id_q),
    .qid          (s_wid),
    .hit          (hit),
    .hit_idx      (hit_idx),
    .older_idle   (older_idle)
  );

  assign s_awready  = ~&vld_q;
  assign s_wready   = hit;
  assign aw_fire    = s_awvalid & s_awready;
  assign w_fire     = s_wvalid & hit;
  assign len_bad    = s_awlen > LEN_W'(MAX_BEATS - 1);
  assign at_end     = wcnt_q[hit_idx] == CNT_W'(len_q[hit_idx]);
  assign head_ready = vld_q[head_q] & done_q[head_q];
  assign head_empty = wcnt_q[head_q] == '0;
  assign m_wvalid   = head_ready & ~head_empty;
  assign m_wlast    = (CNT_W'(rcnt_q) + 1'b1) == wcnt_q[head_q];
  assign r_fire     = m_wvalid & m_wready;
  assign mem_we     = (act == BEAT_KEEP) | (act == BEAT_KEEP_CLOSE);
  assign err_flags  = err_q;

  // next-state process
  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    id_d   = id_q;
    len_d  = len_q;
    wcnt_d = wcnt_q;
    head_d = head_q;
    tail_d = tail_q;
    rcnt_d = rcnt_q;
    err_d  = err_q;
    act    = BEAT_IDLE;

    // address intake: one slot per address, in arrival order
    if (aw_fire) begin
      if (len_bad) begin
        err_d[ERR_AWLEN] = 1'b1;
      end else begin
        vld_d[tail_q]  = 1'b1;
        done_d[tail_q] = 1'b0;
        id_d[tail_q]   = s_awid;
        len_d[tail_q]  = BEAT_W'(s_awlen);
        wcnt_d[tail_q] = '0;
        tail_d         = ptr_inc(tail_q);
      end
    end

    // data intake
    if (w_fire) begin
      if (s_wlast != at_end)  act = BEAT_DROP_CLOSE;
      else if (at_end)        act = BEAT_KEEP_CLOSE;
      else                    act = BEAT_KEEP;
      if ((wcnt_q[hit_idx] == '0) && older_idle) err_d[ERR_ORDER] = 1'b1;
    end

    case (act)
      BEAT_KEEP: wcnt_d[hit_idx] = wcnt_q[hit_idx] + 1'b1;
      BEAT_KEEP_CLOSE: begin
        wcnt_d[hit_idx] = wcnt_q[hit_idx] + 1'b1;
        done_d[hit_idx] = 1'b1;
      end
      BEAT_DROP_CLOSE: begin
        done_d[hit_idx] = 1'b1;
        err_d[ERR_LAST] = 1'b1;
      end
      default: ;
    endcase

    // replay from the ring head
    if (r_fire) begin
      if (m_wlast) begin
        vld_d[head_q] = 1'b0;
        head_d        = ptr_inc(head_q);
        rcnt_d        = '0;
      end else begin
        rcnt_d = rcnt_q + 1'b1;
      end
    end else if (head_ready && head_empty) begin
      vld_d[head_q] = 1'b0;
      head_d        = ptr_inc(head_q);
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      id_q   <= '0;
      len_q  <= '0;
      wcnt_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      rcnt_q <= '0;
      err_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      id_q   <= id_d;
      len_q  <= len_d;
      wcnt_q <= wcnt_d;
      head_q <= head_d;
      tail_q <= tail_d;
      rcnt_q <= rcnt_d;
      err_q  <= err_d;
    end
  end

  wr_deint_store #(
    .DEPTH     (DEPTH),
    .MAX_BEATS (MAX_BEATS),
    .DATA_W    (DATA_W),
    .PTR_W     (PTR_W),
    .BEAT_W    (BEAT_W)
  ) u_store (
    .clk   (clk),
    .we    (mem_we),
    .wslot (hit_idx),
    .wbeat (BEAT_W'(wcnt_q[hit_idx])),
    .wdata (s_wdata),
    .wstrb (s_wstrb),
    .rslot (head_q),
    .rbeat (rcnt_q),
    .rdata (m_wdata),
    .rstrb (m_wstrb)
  );
endmodule

// File: rtl/wr_deint_chk.sv
module wr_deint_chk #(
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int DEPTH     = 4,
  parameter int MAX_BEATS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                s_awvalid,
  input logic                s_awready,
  input logic [LEN_W-1:0]    s_awlen,
  input logic                s_wvalid,
  input logic                s_wready,
  input logic                m_wvalid,
  input logic                m_wready,
  input logic [DATA_W-1:0]   m_wdata,
  input logic [DATA_W/8-1:0] m_wstrb,
  input logic                m_wlast,
  input logic [2:0]          err_flags
);
  logic [7:0] pend_q;
  logic       add;
  logic       sub;

  assign add = s_awvalid & s_awready & (s_awlen <= LEN_W'(MAX_BEATS - 1));
  assign sub = m_wvalid & m_wready & m_wlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= '0;
    else if (add && !sub) pend_q <= pend_q + 8'd1;
    else if (sub && !add) pend_q <= pend_q - 8'd1;
  end

  // R2
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n || err_flags != 3'b000)
    (pend_q == 8'(DEPTH)) |-> !s_awready);

  // R3
  orphan_stall_chk: assert property (@(posedge clk) disable iff (!rst_n || err_flags != 3'b000)
    (s_wvalid && s_wready) |-> (pend_q != 8'd0));

  // R4
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n || err_flags != 3'b000)
    (pend_q == 8'd0) |-> !m_wvalid);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb) && $stable(m_wlast)));

  // R5
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && m_wready && !m_wlast) |=> m_wvalid);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((err_flags & $past(err_flags)) == $past(err_flags)));
endmodule

bind wr_deinterleave wr_deint_chk #(
  .DATA_W    (DATA_W),
  .LEN_W     (LEN_W),
  .DEPTH     (DEPTH),
  .MAX_BEATS (MAX_BEATS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .s_awlen   (s_awlen),
  .s_wvalid  (s_wvalid),
  .s_wready  (s_wready),
  .m_wvalid  (m_wvalid),
  .m_wready  (m_wready),
  .m_wdata   (m_wdata),
  .m_wstrb   (m_wstrb),
  .m_wlast   (m_wlast),
  .err_flags (err_flags)
);

// File: tb/wr_deinterleave_test.sv
`timescale 1ns/1ps
module wr_deinterleave_test;
  localparam int DATA_W    = 32;
  localparam int ID_W      = 4;
  localparam int LEN_W     = 8;
  localparam int DEPTH     = 4;
  localparam int MAX_BEATS = 16;
  localparam int STRB_W    = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              s_awvalid;
  logic              s_awready;
  logic [ID_W-1:0]   s_awid;
  logic [LEN_W-1:0]  s_awlen;
  logic              s_wvalid;
  logic              s_wready;
  logic [ID_W-1:0]   s_wid;
  logic [DATA_W-1:0] s_wdata;
  logic [STRB_W-1:0] s_wstrb;
  logic              s_wlast;
  logic              m_wvalid;
  logic              m_wready;
  logic [DATA_W-1:0] m_wdata;
  logic [STRB_W-1:0] m_wstrb;
  logic              m_wlast;
  logic [2:0]        err_flags;

  always #2 clk = ~clk;

  wr_deinterleave #(
    .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .MAX_BEATS(MAX_BEATS)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid), .s_awlen(s_awlen),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wid(s_wid), .s_wdata(s_wdata),
    .s_wstrb(s_wstrb), .s_wlast(s_wlast),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .err_flags(err_flags)
  );

  int checks   = 0;
  int failures = 0;
  int sink_mode = 1;       // 0 hold, 1 random, 2 always ready
  logic in_burst;

  logic [DATA_W-1:0] exp_d [$];
  logic [STRB_W-1:0] exp_s [$];
  logic              exp_l [$];

  int                ids  [DEPTH];
  int                lens [DEPTH];
  int                nxt  [DEPTH];
  logic [DATA_W-1:0] td   [DEPTH][MAX_BEATS];
  logic [STRB_W-1:0] ts   [DEPTH][MAX_BEATS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s, input logic l);
    exp_d.push_back(d);
    exp_s.push_back(s);
    exp_l.push_back(l);
  endtask

  // sink: decides ready on the falling edge and checks the beat taken at the next rising edge
  initial begin
    m_wready = 1'b0;
    in_burst = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n !== 1'b1) begin
        in_burst = 1'b0;
        m_wready = 1'b0;
      end else begin
        if (in_burst) chk(m_wvalid == 1'b1, "R5", "gap inside burst", 64'(m_wvalid), 64'd1);
        case (sink_mode)
          0:       m_wready = 1'b0;
          1:       m_wready = ($urandom % 4) != 0;
          default: m_wready = 1'b1;
        endcase
        if (m_wvalid && m_wready) begin
          if (exp_d.size() == 0) begin
            chk(1'b0, "R4", "unexpected output beat", 64'(m_wdata), 64'd0);
          end else begin
            logic [DATA_W-1:0] d;
            logic [STRB_W-1:0] s;
            logic              l;
            d = exp_d.pop_front();
            s = exp_s.pop_front();
            l = exp_l.pop_front();
            chk(m_wdata == d && m_wstrb == s && m_wlast == l, "R4", "output beat",
                64'({m_wlast, m_wstrb, m_wdata}), 64'({l, s, d}));
          end
          in_burst = !m_wlast;
        end
      end
    end
  end

  task automatic aw_send(input int id, input int len);
    bit r;
    s_awvalid = 1'b1;
    s_awid    = ID_W'(id);
    s_awlen   = LEN_W'(len);
    do begin
      #1 r = s_awready;
      @(negedge clk);
    end while (!r);
    s_awvalid = 1'b0;
  endtask

  task automatic w_send(input int id, input logic [DATA_W-1:0] d,
                        input logic [STRB_W-1:0] s, input logic l);
    bit r;
    s_wvalid = 1'b1;
    s_wid    = ID_W'(id);
    s_wdata  = d;
    s_wstrb  = s;
    s_wlast  = l;
    do begin
      #1 r = s_wready;
      @(negedge clk);
    end while (!r);
    s_wvalid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    s_awvalid = 1'b0;
    s_wvalid  = 1'b0;
    s_awid    = '0;
    s_awlen   = '0;
    s_wid     = '0;
    s_wdata   = '0;
    s_wstrb   = '0;
    s_wlast   = 1'b0;
    exp_d.delete();
    exp_s.delete();
    exp_l.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    sink_mode = 2;
    while (exp_d.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_d.size() == 0 && !m_wvalid, req, "drain complete", 64'(exp_d.size()), 64'd0);
    sink_mode = 1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired: actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1877);

    // R1 reset state, R3 orphan beat stalls
    do_reset();
    chk(m_wvalid == 1'b0, "R1", "m_wvalid after reset", 64'(m_wvalid), 64'd0);
    chk(s_awready == 1'b1, "R1", "s_awready after reset", 64'(s_awready), 64'd1);
    chk(err_flags == 3'b000, "R1", "err_flags after reset", 64'(err_flags), 64'd0);
    s_wvalid = 1'b1; s_wid = 4'd3;
    #1 chk(s_wready == 1'b0, "R3", "beat with no address", 64'(s_wready), 64'd0);
    s_wvalid = 1'b0;
    @(negedge clk);

    // R3 beat before its address is held, then taken
    push_exp(32'hA5A5_0001, 4'hF, 1'b1);
    fork
      w_send(5, 32'hA5A5_0001, 4'hF, 1'b1);
      begin
        repeat (4) @(negedge clk);
        #1 chk(s_wready == 1'b0, "R3", "early beat still stalled", 64'(s_wready), 64'd0);
        @(negedge clk);
        aw_send(5, 0);
      end
    join
    drain("R3");

    // R2 depth limit with sink held off
    sink_mode = 0;
    for (int j = 0; j < DEPTH; j++) begin
      aw_send(j + 1, 0);
      push_exp(32'hD0 + 32'(j), 4'(j + 1), 1'b1);
    end
    chk(s_awready == 1'b0, "R2", "awready with all slots pending", 64'(s_awready), 64'd0);
    for (int j = 0; j < DEPTH; j++) w_send(j + 1, 32'hD0 + 32'(j), 4'(j + 1), 1'b1);
    chk(m_wvalid == 1'b1, "R4", "head burst ready", 64'(m_wvalid), 64'd1);
    push_exp(32'hE5, 4'h3, 1'b1);
    fork
      aw_send(9, 0);
      begin
        repeat (3) @(negedge clk);
        chk(s_awready == 1'b0, "R2", "fifth address stalled", 64'(s_awready), 64'd0);
        sink_mode = 2;
      end
    join
    w_send(9, 32'hE5, 4'h3, 1'b1);
    drain("R2");

    // R6 same-ID bursts with another ID between
    aw_send(2, 1);
    aw_send(4, 0);
    aw_send(2, 0);
    push_exp(32'h1111_0000, 4'h1, 1'b0);
    push_exp(32'h1111_0001, 4'h2, 1'b1);
    push_exp(32'h2222_0000, 4'h4, 1'b1);
    push_exp(32'h3333_0000, 4'h8, 1'b1);
    w_send(2, 32'h1111_0000, 4'h1, 1'b0);
    w_send(4, 32'h2222_0000, 4'h4, 1'b1);
    w_send(2, 32'h1111_0001, 4'h2, 1'b1);
    w_send(2, 32'h3333_0000, 4'h8, 1'b1);
    drain("R6");
    chk(err_flags == 3'b000, "R6", "no error for legal same-ID use", 64'(err_flags), 64'd0);

    // R7 first beat overtakes an older burst
    do_reset();
    aw_send(6, 1);
    aw_send(7, 0);
    push_exp(32'h6000_0000, 4'hF, 1'b0);
    push_exp(32'h6000_0001, 4'hF, 1'b1);
    push_exp(32'h7000_0000, 4'h5, 1'b1);
    w_send(7, 32'h7000_0000, 4'h5, 1'b1);
    chk(err_flags == 3'b001, "R7", "order flag", 64'(err_flags), 64'd1);
    w_send(6, 32'h6000_0000, 4'hF, 1'b0);
    w_send(6, 32'h6000_0001, 4'hF, 1'b1);
    drain("R7");
    chk(err_flags == 3'b001, "R10", "flag held", 64'(err_flags), 64'd1);

    // R8 oversize length rejected, then the maximum length works
    do_reset();
    chk(err_flags == 3'b000, "R1", "reset clears flags", 64'(err_flags), 64'd0);
    aw_send(9, MAX_BEATS);
    chk(err_flags == 3'b010, "R8", "length flag", 64'(err_flags), 64'd2);
    chk(s_awready == 1'b1, "R8", "no slot taken", 64'(s_awready), 64'd1);
    s_wvalid = 1'b1; s_wid = 4'd9;
    #1 chk(s_wready == 1'b0, "R8", "beat for rejected address stalls", 64'(s_wready), 64'd0);
    s_wvalid = 1'b0;
    @(negedge clk);
    aw_send(9, MAX_BEATS - 1);
    for (int b = 0; b < MAX_BEATS; b++) begin
      push_exp(32'h9900_0000 + 32'(b), 4'(b), b == MAX_BEATS - 1);
    end
    for (int b = 0; b < MAX_BEATS; b++) w_send(9, 32'h9900_0000 + 32'(b), 4'(b), b == MAX_BEATS - 1);
    drain("R8");

    // R9 early last marker, missing last marker
    do_reset();
    aw_send(1, 2);
    push_exp(32'hB000_0000, 4'hC, 1'b1);
    w_send(1, 32'hB000_0000, 4'hC, 1'b0);
    w_send(1, 32'hB000_0001, 4'hC, 1'b1);
    chk(err_flags == 3'b100, "R9", "early last flag", 64'(err_flags), 64'd4);
    drain("R9");
    aw_send(2, 0);
    w_send(2, 32'hBAD0_0000, 4'hF, 1'b0);
    aw_send(3, 0);
    push_exp(32'hC000_0000, 4'h9, 1'b1);
    w_send(3, 32'hC000_0000, 4'h9, 1'b1);
    drain("R9");

    // R4 random interleaving respecting the first-beat order
    do_reset();
    for (int rnd = 0; rnd < 40; rnd++) begin
      int k;
      int s;
      int left;
      k = 1 + int'($urandom % DEPTH);
      left = 0;
      for (int j = 0; j < k; j++) begin
        ids[j]  = (rnd * 5 + j) % 16;
        lens[j] = int'($urandom % MAX_BEATS);
        nxt[j]  = 0;
        left += lens[j] + 1;
        for (int b = 0; b <= lens[j]; b++) begin
          td[j][b] = $urandom;
          ts[j][b] = STRB_W'($urandom);
          push_exp(td[j][b], ts[j][b], b == lens[j]);
        end
      end
      for (int j = 0; j < k; j++) aw_send(ids[j], lens[j]);
      s = 0;
      while (left > 0) begin
        int j;
        j = int'($urandom % ((s < k) ? s + 1 : k));
        if (nxt[j] <= lens[j]) begin
          w_send(ids[j], td[j][nxt[j]], ts[j][nxt[j]], nxt[j] == lens[j]);
          nxt[j]++;
          if (j == s) s++;
          left--;
        end
      end
    end
    drain("R4");
    chk(err_flags == 3'b000, "R4", "no error on legal random traffic", 64'(err_flags), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule